// File: doc/BRIEF.md
# SPI Byte Shift Engine

This block moves one byte in each direction per SPI transfer and can play either side of the link. As master it divides the system clock to produce the serial clock and drives the data-out line. It frames each transfer with an active-low select and captures the peer's data-in line. As slave it follows a serial clock, data line and select that arrive from outside. It brings them into the system clock domain and returns its own byte on a data line whose output enable is only active while it is selected.

Three run-time inputs set the transfer format. The polarity input sets the clock idle level. The phase input chooses whether the first clock edge of a bit samples or launches data. The order input picks whether the byte goes most-significant or least-significant bit first. Sampling and launching always fall on opposite serial-clock edges. The user side is deliberately thin: a start strobe that loads the transmit byte, a receive byte, and a one-cycle done pulse that marks the moment the eighth bit has been captured.

Top module: `spi_xfer_engine`

## Requirements
- R1: After reset, `m_sel_n_o` is 1, `done` is 0, `rx_byte` is 0 and `s_miso_oe` is 0. From the second clock after reset, `m_sck_o` equals `cpol`.
- R2: As master, `m_sck_o` rests at `cpol` whenever select is high. Each transfer produces exactly 16 serial-clock edges. The select fall and every edge are spaced by `div_half` system clocks, and a value of 0 acts as 1.
- R3: The four modes are numbered polarity*2+phase. Modes 0 and 3 sample on rising edges, and modes 1 and 2 on falling edges. Output data only changes on the edge type that is not the sampling edge.
- R4: With `cpha`=0, the first bit is already on `m_mosi_o` in the cycle select goes low. That bit is `tx_byte[7]`, or `tx_byte[0]` when `lsb_first`=1.
- R5: `lsb_first`=0 sends bit 7 first down to bit 0. `lsb_first`=1 sends bit 0 first up to bit 7. Received bits are placed using the same order.
- R6: `done` is high for exactly one cycle per completed byte. In that cycle `rx_byte` already holds the full received byte, and it keeps that value until the next `done`.
- R7: In master mode, a `start` pulse seen while idle drops `m_sel_n_o` on the next clock edge. `m_sel_n_o` rises `div_half` clocks after the 16th edge. A `start` seen during a transfer, including the cycle right after `done`, is ignored.
- R8: In slave mode, `s_sck_i`, `s_mosi_i` and `s_sel_n_i` pass through a two-stage synchronizer. The block samples `s_mosi_i` on the mode's sampling edge and presents its byte on `s_miso_o`. A `start` pulse loads `tx_byte` whenever no partial byte is in progress. `s_miso_oe` is 1 while select is low.
- R9: In slave mode, a high select drives `s_miso_oe` to 0 and discards any partial byte. An aborted transfer therefore yields no `done`, and the next full transfer is received correctly.
- R10: With `cpha`=1, the first leading edge launches the first bit without shifting it away. The eighth sample falls on the 16th edge, which is trailing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| is_master | input | 1 | 1 selects master operation, 0 slave |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | 0 samples on leading edge, 1 on trailing edge |
| lsb_first | input | 1 | 0 sends bit 7 first, 1 sends bit 0 first |
| div_half | input | DIV_W | Master clock half-period in system clocks (0 treated as 1) |
| start | input | 1 | Load strobe for `tx_byte`; in master mode it also starts a transfer |
| tx_byte | input | DATA_W | Byte to transmit |
| rx_byte | output | DATA_W | Last complete byte received |
| done | output | 1 | One-cycle pulse when a byte has been received |
| m_sck_o | output | 1 | Master serial clock |
| m_mosi_o | output | 1 | Master data out |
| m_miso_i | input | 1 | Master data in |
| m_sel_n_o | output | 1 | Master active-low select |
| s_sck_i | input | 1 | Slave serial clock in |
| s_mosi_i | input | 1 | Slave data in |
| s_sel_n_i | input | 1 | Slave active-low select in |
| s_miso_o | output | 1 | Slave data out |
| s_miso_oe | output | 1 | Slave data-out enable (0 means released) |

## Verification
The collision that matters is a new `start` arriving right after the eighth sample raises `done`, while the master is still holding select. In phase-0 modes one serial-clock edge remains at that point, and in phase-1 modes only the tail delay remains. The bench watches `done` and drives `start` with a different byte into the very next clock. It then judges the result from the peer's view: only one select fall per transfer, the peer still receives the original byte, and the edge count stays at 16. The same run also sets the half-period to zero, so the fastest edge spacing is exercised during that collision.

// File: rtl/spi_xfer_pkg.sv
// Shared types and helpers for the SPI byte shift engine.
// Assumes: mode encoding polarity*2+phase; helpers are pure combinational.
package spi_xfer_pkg;

    // Master sequencing states
    typedef enum logic [1:0] {
        M_IDLE = 2'd0,
        M_RUN  = 2'd1,
        M_TAIL = 2'd2
    } mst_state_e;

    // A leading edge samples when phase is 0; a trailing edge samples when phase is 1
    function automatic logic is_sample_edge(input logic leading, input logic cpha);
        return leading ^ cpha;
    endfunction

    // Pick which detected transition is the leading one for a given idle level
    function automatic logic lead_of(input logic rose, input logic fell, input logic cpol);
        return cpol ? fell : rose;
    endfunction

endpackage

// File: rtl/spi_sync_bank.sv
// Multi-bit chain of flip-flops that brings asynchronous pins into the clock domain.
// Assumes: each bit is independent; STAGES >= 1; RESET_VAL is the inactive level.
module spi_sync_bank #(
    parameter int                WIDTH     = 3,
    parameter int                STAGES    = 2,
    parameter logic [WIDTH-1:0]  RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    // Shift the pin values one stage deeper every clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg[i] <= RESET_VAL;
            end
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_clk_div.sv
// Master serial-clock generator: half-period divider plus edge counter.
// Assumes: count_en covers both the toggling phase and the tail wait;
// toggle_en low parks the clock at the polarity level.
module spi_clk_div #(
    parameter int DIV_W = 8,
    parameter int EDGES = 16,
    localparam int EW   = $clog2(EDGES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic             toggle_en,
    input  logic             cpol,
    input  logic [DIV_W-1:0] half,
    output logic             tick,
    output logic             sck,
    output logic [EW-1:0]    edge_idx
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W:0]   cnt_nx;

    // Half-period elapsed; a zero setting behaves like one
    assign cnt_nx = {1'b0, cnt} + {{DIV_W{1'b0}}, 1'b1};
    assign tick   = count_en && (cnt_nx >= {1'b0, half});

    // Divider counter runs only while the sequencer needs timing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!count_en || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt_nx[DIV_W-1:0];
        end
    end

    // Serial clock toggles on ticks, otherwise rests at the idle level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck <= 1'b0;
        end else if (!toggle_en) begin
            sck <= cpol;
        end else if (tick) begin
            sck <= ~sck;
        end
    end

    // Count edges produced in the current transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_idx <= '0;
        end else if (!toggle_en) begin
            edge_idx <= '0;
        end else if (tick) begin
            edge_idx <= edge_idx + EW'(1);
        end
    end

endmodule

// File: rtl/spi_shift_core.sv
// Transmit and receive shift registers with run-time bit order and a bit counter.
// Assumes: sample and shift strobes never coincide; load wins over all else.
module spi_shift_core #(
    parameter int DATA_W = 8,
    localparam int CW    = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lsb_first,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              clr_cnt,
    input  logic              sample,
    input  logic              sample_bit,
    input  logic              shift,
    output logic              out_bit,
    output logic              cnt_zero,
    output logic [DATA_W-1:0] rx_data,
    output logic              done
);

    localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

    logic [DATA_W-1:0] tx_sr;
    logic [DATA_W-1:0] rx_sr;
    logic [DATA_W-1:0] rx_nx;
    logic [CW-1:0]     bit_cnt;

    // Next receive value with the incoming bit placed per bit order
    assign rx_nx = lsb_first ? {sample_bit, rx_sr[DATA_W-1:1]}
                             : {rx_sr[DATA_W-2:0], sample_bit};

    assign out_bit  = lsb_first ? tx_sr[0] : tx_sr[DATA_W-1];
    assign cnt_zero = (bit_cnt == '0);

    // Transmit register: load, or advance after at least one sample this byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr <= '0;
        end else if (load) begin
            tx_sr <= load_data;
        end else if (shift && !cnt_zero) begin
            tx_sr <= lsb_first ? (tx_sr >> 1) : (tx_sr << 1);
        end
    end

    // Receive register and bit counter, with completion pulse on the last bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sr   <= '0;
            rx_data <= '0;
            bit_cnt <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load || clr_cnt) begin
                bit_cnt <= '0;
            end else if (sample) begin
                rx_sr <= rx_nx;
                if (bit_cnt == LAST) begin
                    bit_cnt <= '0;
                    rx_data <= rx_nx;
                    done    <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + CW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/spi_xfer_engine.sv
// SPI byte shift engine, master or slave, with run-time polarity, phase and bit order.
// Assumes: cpol, cpha, lsb_first and is_master are held steady during a transfer;
// slave pins are asynchronous and slower than a few system clocks per half-period.
module spi_xfer_engine
    import spi_xfer_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_master,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              lsb_first,
    input  logic [DIV_W-1:0]  div_half,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_byte,
    output logic [DATA_W-1:0] rx_byte,
    output logic              done,
    output logic              m_sck_o,
    output logic              m_mosi_o,
    input  logic              m_miso_i,
    output logic              m_sel_n_o,
    input  logic              s_sck_i,
    input  logic              s_mosi_i,
    input  logic              s_sel_n_i,
    output logic              s_miso_o,
    output logic              s_miso_oe
);

    localparam int EDGES = 2 * DATA_W;
    localparam int EW    = $clog2(EDGES);

    // ---------------- master sequencing ----------------
    mst_state_e    m_state;
    logic          m_sel_q;
    logic          m_tick;
    logic          m_sck;
    logic [EW-1:0] m_edge;
    logic          m_lead;
    logic          m_last;
    logic          m_go;
    logic          m_sample;
    logic          m_shift;

    spi_clk_div #(
        .DIV_W (DIV_W),
        .EDGES (EDGES)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .count_en  (m_state != M_IDLE),
        .toggle_en (m_state == M_RUN),
        .cpol      (cpol),
        .half      (div_half),
        .tick      (m_tick),
        .sck       (m_sck),
        .edge_idx  (m_edge)
    );

    assign m_lead   = ~m_edge[0];
    assign m_last   = (m_edge == EW'(EDGES - 1));
    assign m_go     = is_master && start && (m_state == M_IDLE);
    assign m_sample = is_master && (m_state == M_RUN) && m_tick &&  is_sample_edge(m_lead, cpha);
    assign m_shift  = is_master && (m_state == M_RUN) && m_tick && !is_sample_edge(m_lead, cpha);

    // Master state machine: idle, clocking 16 edges, then a half-period tail before release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_state <= M_IDLE;
            m_sel_q <= 1'b1;
        end else begin
            case (m_state)
                M_IDLE: begin
                    if (m_go) begin
                        m_state <= M_RUN;
                        m_sel_q <= 1'b0;
                    end
                end
                M_RUN: begin
                    if (m_tick && m_last) begin
                        m_state <= M_TAIL;
                    end
                end
                M_TAIL: begin
                    if (m_tick) begin
                        m_state <= M_IDLE;
                        m_sel_q <= 1'b1;
                    end
                end
                default: begin
                    m_state <= M_IDLE;
                    m_sel_q <= 1'b1;
                end
            endcase
        end
    end

    // ---------------- slave front end ----------------
    logic [2:0] s_sync;
    logic       s_sck;
    logic       s_mosi;
    logic       s_sel_n;
    logic       s_sck_prev;
    logic       s_rose;
    logic       s_fell;
    logic       s_act;
    logic       s_lead;
    logic       s_trail;
    logic       s_sample;
    logic       s_shift;
    logic       s_load;
    logic       cnt_zero;

    spi_sync_bank #(
        .WIDTH     (3),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (3'b001)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({s_sck_i, s_mosi_i, s_sel_n_i}),
        .q     (s_sync)
    );

    assign s_sck   = s_sync[2];
    assign s_mosi  = s_sync[1];
    assign s_sel_n = s_sync[0];

    // Remember the previous synchronized clock for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_sck_prev <= 1'b0;
        end else begin
            s_sck_prev <= s_sck;
        end
    end

    assign s_rose   =  s_sck & ~s_sck_prev;
    assign s_fell   = ~s_sck &  s_sck_prev;
    assign s_act    = !is_master && !s_sel_n;
    assign s_lead   = lead_of(s_rose, s_fell, cpol);
    assign s_trail  = lead_of(s_fell, s_rose, cpol);
    assign s_sample = s_act && (cpha ? s_trail : s_lead);
    assign s_shift  = s_act && (cpha ? s_lead  : s_trail);
    assign s_load   = !is_master && start && cnt_zero;

    // ---------------- shared shifter ----------------
    logic sh_out;

    spi_shift_core #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .lsb_first  (lsb_first),
        .load       (m_go || s_load),
        .load_data  (tx_byte),
        .clr_cnt    (!is_master && s_sel_n),
        .sample     (is_master ? m_sample : s_sample),
        .sample_bit (is_master ? m_miso_i : s_mosi),
        .shift      (is_master ? m_shift  : s_shift),
        .out_bit    (sh_out),
        .cnt_zero   (cnt_zero),
        .rx_data    (rx_byte),
        .done       (done)
    );

    assign m_sck_o   = m_sck;
    assign m_mosi_o  = sh_out;
    assign m_sel_n_o = m_sel_q;
    assign s_miso_o  = sh_out;
    assign s_miso_oe = s_act;

endmodule

// File: rtl/spi_xfer_engine_chk.sv
// Property checker for the SPI byte shift engine, attached by bind.
// Assumes: observes ports only; an age counter keeps history checks inside the time since reset.
module spi_xfer_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic is_master,
    input logic cpol,
    input logic cpha,
    input logic lsb_first,
    input logic start,
    input logic tx_first_msb,
    input logic tx_first_lsb,
    input logic done,
    input logic m_sck_o,
    input logic m_mosi_o,
    input logic m_sel_n_o,
    input logic s_sel_n_i,
    input logic s_miso_oe
);

    logic [1:0] age;
    logic       armed;

    // Count cycles since reset, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age <= 2'd0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    assign armed = (age == 2'd3);

    assert_idle_sck_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && is_master && m_sel_n_o && $past(m_sel_n_o) && $stable(cpol)) |-> (m_sck_o == cpol));

    assert_opposite_edges_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && is_master && !m_sel_n_o && $past(!m_sel_n_o) && !$stable(m_sck_o)
         && (m_sck_o == !(cpol ^ cpha))) |-> $stable(m_mosi_o));

    assert_first_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $fell(m_sel_n_o) && !cpha)
            |-> (m_mosi_o == (lsb_first ? $past(tx_first_lsb) : $past(tx_first_msb))));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_sel_from_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $fell(m_sel_n_o)) |-> ($past(start) && $past(is_master)));

    assert_miso_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(s_sel_n_i, 2)) |-> !s_miso_oe);

endmodule

bind spi_xfer_engine spi_xfer_engine_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .is_master    (is_master),
    .cpol         (cpol),
    .cpha         (cpha),
    .lsb_first    (lsb_first),
    .start        (start),
    .tx_first_msb (tx_byte[DATA_W-1]),
    .tx_first_lsb (tx_byte[0]),
    .done         (done),
    .m_sck_o      (m_sck_o),
    .m_mosi_o     (m_mosi_o),
    .m_sel_n_o    (m_sel_n_o),
    .s_sel_n_i    (s_sel_n_i),
    .s_miso_oe    (s_miso_oe)
);

// File: tb/test_spi_xfer_engine.sv
// Directed bench for the SPI byte shift engine: a peer model for master runs,
// and pin-driving tasks for slave runs.
module test_spi_xfer_engine;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       is_master = 1'b1;
    logic       cpol = 1'b0;
    logic       cpha = 1'b0;
    logic       lsb_first = 1'b0;
    logic [7:0] div_half = 8'd2;
    logic       start = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic [7:0] rx_byte;
    logic       done;
    logic       m_sck_o;
    logic       m_mosi_o;
    logic       m_miso_i = 1'b0;
    logic       m_sel_n_o;
    logic       s_sck_i = 1'b0;
    logic       s_mosi_i = 1'b0;
    logic       s_sel_n_i = 1'b1;
    logic       s_miso_o;
    logic       s_miso_oe;

    int vectors = 0;
    int fails   = 0;
    int cyc     = 0;
    bit finished = 0;

    spi_xfer_engine i_spi_xfer_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .is_master (is_master),
        .cpol      (cpol),
        .cpha      (cpha),
        .lsb_first (lsb_first),
        .div_half  (div_half),
        .start     (start),
        .tx_byte   (tx_byte),
        .rx_byte   (rx_byte),
        .done      (done),
        .m_sck_o   (m_sck_o),
        .m_mosi_o  (m_mosi_o),
        .m_miso_i  (m_miso_i),
        .m_sel_n_o (m_sel_n_o),
        .s_sck_i   (s_sck_i),
        .s_mosi_i  (s_mosi_i),
        .s_sel_n_i (s_sel_n_i),
        .s_miso_o  (s_miso_o),
        .s_miso_oe (s_miso_oe)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Peer model and output monitors, evaluated at the falling system edge
    logic [7:0] peer_tx = 8'h00;
    logic [7:0] peer_sr = 8'h00;
    logic [7:0] peer_rx = 8'h00;
    logic [7:0] last_rx = 8'h00;
    int  peer_cnt = 0;
    int  edges = 0;
    int  min_gap = 0;
    int  max_gap = 0;
    int  last_t = 0;
    int  sel_falls = 0;
    int  done_cnt = 0;
    int  dbl_done = 0;
    logic first_mosi = 1'b0;
    logic prev_sel = 1'b1;
    logic prev_sck = 1'b0;
    logic prev_done = 1'b0;

    always @(negedge clk) begin
        if (prev_sel && !m_sel_n_o) begin
            sel_falls++;
            peer_cnt   = 0;
            peer_sr    = peer_tx;
            peer_rx    = 8'h00;
            m_miso_i   = lsb_first ? peer_sr[0] : peer_sr[7];
            first_mosi = m_mosi_o;
            edges      = 0;
            min_gap    = 1000;
            max_gap    = 0;
            last_t     = cyc;
        end else if (!m_sel_n_o && (m_sck_o != prev_sck)) begin
            if (cyc - last_t < min_gap) min_gap = cyc - last_t;
            if (cyc - last_t > max_gap) max_gap = cyc - last_t;
            last_t = cyc;
            edges++;
            if (m_sck_o == !(cpol ^ cpha)) begin
                peer_rx = lsb_first ? {m_mosi_o, peer_rx[7:1]} : {peer_rx[6:0], m_mosi_o};
                peer_cnt++;
            end else if (peer_cnt > 0 && peer_cnt < 8) begin
                peer_sr  = lsb_first ? (peer_sr >> 1) : (peer_sr << 1);
                m_miso_i = lsb_first ? peer_sr[0] : peer_sr[7];
            end
        end
        prev_sel = m_sel_n_o;
        prev_sck = m_sck_o;
        if (done) begin
            done_cnt++;
            last_rx = rx_byte;
        end
        if (done && prev_done) dbl_done++;
        prev_done = done;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R1: state right after reset
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(m_sel_n_o == 1'b1, "R1 select high", m_sel_n_o, 1);
        chk(done == 1'b0, "R1 done low", done, 0);
        chk(rx_byte == 8'h00, "R1 rx_byte clear", rx_byte, 0);
        chk(m_sck_o == cpol, "R1 sck at idle", m_sck_o, cpol);
        chk(s_miso_oe == 1'b0, "R1 miso released", s_miso_oe, 0);
    endtask

    // One master transfer with the peer model; poke re-strobes start after done
    task automatic master_xfer(input int mode, input bit lsb, input int div,
                               input logic [7:0] mtx, input logic [7:0] ptx, input bit poke);
        int d0;
        int f0;
        int eff;
        int guard;
        logic exp_first;
        is_master = 1'b1;
        cpol      = mode[1];
        cpha      = mode[0];
        lsb_first = lsb;
        div_half  = 8'(div);
        peer_tx   = ptx;
        eff       = (div == 0) ? 1 : div;
        repeat (4) @(negedge clk);
        d0 = done_cnt;
        f0 = sel_falls;
        tx_byte = mtx;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        chk(m_sel_n_o == 1'b0, "R7 select falls after start", m_sel_n_o, 0);
        guard = 0;
        while (m_sel_n_o == 1'b0 && guard < 2000) begin
            @(negedge clk);
            guard++;
            if (poke && done) begin
                start   = 1'b1;
                tx_byte = ~mtx;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        repeat (3) @(negedge clk);
        exp_first = lsb ? mtx[0] : mtx[7];
        chk(peer_rx == mtx, cpha ? "R3 R5 R10 peer received" : "R3 R5 peer received", peer_rx, mtx);
        chk(last_rx == ptx, "R6 rx_byte at done", last_rx, ptx);
        chk(rx_byte == ptx, "R6 rx_byte held", rx_byte, ptx);
        chk(done_cnt == d0 + 1, "R6 one done per byte", done_cnt - d0, 1);
        chk(edges == 16, "R2 edge count", edges, 16);
        chk(min_gap == eff && max_gap == eff, "R2 half period", max_gap, eff);
        chk(m_sck_o == cpol, "R2 sck idle after", m_sck_o, cpol);
        chk(sel_falls == f0 + 1, "R7 single select fall", sel_falls - f0, 1);
        if (!cpha) chk(first_mosi == exp_first, "R4 first bit before first edge", first_mosi, exp_first);
    endtask

    // One slave transfer driven by the bench; abort_n > 0 stops after that many bits
    task automatic slave_xfer(input int mode, input bit lsb, input logic [7:0] stx,
                              input logic [7:0] mtx, input int abort_n);
        int d0;
        int nbits;
        int hp;
        logic [7:0] brx;
        hp = 8;
        brx = 8'h00;
        is_master = 1'b0;
        cpol      = mode[1];
        cpha      = mode[0];
        lsb_first = lsb;
        s_sck_i   = mode[1];
        s_sel_n_i = 1'b1;
        s_mosi_i  = 1'b0;
        repeat (6) @(negedge clk);
        tx_byte = stx;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        repeat (2) @(negedge clk);
        d0 = done_cnt;
        nbits = (abort_n > 0) ? abort_n : 8;
        if (!cpha) s_mosi_i = lsb ? mtx[0] : mtx[7];
        s_sel_n_i = 1'b0;
        repeat (hp) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            int idx;
            idx = lsb ? i : 7 - i;
            if (!cpha) begin
                brx[idx] = s_miso_o;
                s_sck_i  = ~s_sck_i;
                repeat (hp) @(negedge clk);
                s_sck_i  = ~s_sck_i;
                if (i < 7) s_mosi_i = lsb ? mtx[i+1] : mtx[6-i];
                repeat (hp) @(negedge clk);
            end else begin
                s_sck_i  = ~s_sck_i;
                s_mosi_i = mtx[idx];
                repeat (hp) @(negedge clk);
                brx[idx] = s_miso_o;
                s_sck_i  = ~s_sck_i;
                repeat (hp) @(negedge clk);
            end
            if (i == 2) chk(s_miso_oe == 1'b1, "R8 miso driven while selected", s_miso_oe, 1);
        end
        s_sel_n_i = 1'b1;
        repeat (6) @(negedge clk);
        chk(s_miso_oe == 1'b0, "R9 miso released on deselect", s_miso_oe, 0);
        if (abort_n > 0) begin
            chk(done_cnt == d0, "R9 aborted byte gives no done", done_cnt - d0, 0);
        end else begin
            chk(done_cnt == d0 + 1, "R6 slave one done", done_cnt - d0, 1);
            chk(last_rx == mtx, "R8 R5 slave received", last_rx, mtx);
            chk(brx == stx, "R8 R5 slave transmitted", brx, stx);
        end
    endtask

    initial begin
        t_reset();
        master_xfer(0, 1'b0, 2, 8'hA5, 8'h3C, 1'b0);
        master_xfer(1, 1'b0, 2, 8'h96, 8'h5A, 1'b0);
        master_xfer(2, 1'b0, 3, 8'h81, 8'h7E, 1'b0);
        master_xfer(3, 1'b0, 2, 8'hC3, 8'h18, 1'b0);
        master_xfer(0, 1'b1, 1, 8'h01, 8'h80, 1'b0);
        master_xfer(1, 1'b1, 4, 8'hB4, 8'h2D, 1'b0);
        master_xfer(2, 1'b1, 0, 8'hF0, 8'h0F, 1'b1);
        master_xfer(3, 1'b1, 2, 8'h6C, 8'hE1, 1'b1);
        master_xfer(1, 1'b0, 1, 8'h5B, 8'hD2, 1'b1);
        slave_xfer(0, 1'b0, 8'h3C, 8'hA5, 0);
        slave_xfer(1, 1'b0, 8'h9E, 8'h47, 0);
        slave_xfer(2, 1'b1, 8'h12, 8'hE8, 0);
        slave_xfer(3, 1'b1, 8'hC5, 8'h6A, 0);
        slave_xfer(0, 1'b0, 8'hFF, 8'h00, 3);
        slave_xfer(0, 1'b0, 8'h71, 8'h8D, 0);
        slave_xfer(3, 1'b0, 8'h00, 8'hFF, 5);
        slave_xfer(3, 1'b0, 8'hB2, 8'h4E, 0);
        chk(dbl_done == 0, "R6 done never two cycles", dbl_done, 0);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            vectors++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule